// File: doc/BRIEF.md
# Eager Register Release Tracker

This block keeps a small usage record for every physical register of a renamed out-of-order core. With it, an old physical mapping goes back to the free list as soon as two things hold: a newer mapping has replaced its logical register, and every reader renamed against it has obtained the value. The block does not wait for older branches to resolve. Each register also stores where a redundant copy of its value sits in the value queue that feeds the checking thread. A released value can therefore be restored if the overwriting instruction turns out to be on a wrong path.

Rename supplies one mapping change (new and old physical register) and at most one reader per cycle. Issue reports readers that have obtained their operand, and commit reports overwriting instructions that have retired. A mispredict brings a mask of squashed checkpoints. The block then streams one copy-back request per cycle, and each request carries the register index and the location of its duplicate. A done pulse marks the end of recovery, and recovery never takes less than a fixed latency.

Top module: `eager_release_tracker`

## Requirements
- R1: After reset no release, copy-back, stall or done output is asserted, and no register counts as overwritten.
- R2: A register whose logical register has been remapped (it appears as `ren_old_preg`) and whose pending reader count is zero is reported on `rel_valid`/`rel_preg` exactly once, whether or not the overwrite is speculative. The report appears in the cycle after that state is reached.
- R3: A reader renamed with `rd_valid` increments the register's pending count, and `iss_valid` decrements it. A register with a non-zero count is not released until issues bring the count to zero.
- R4: The pending count saturates at 3. A reader rename to a register whose count is 3 raises `ren_stall` in the same cycle, and that cycle's whole rename (mapping change and reader) is dropped.
- R5: When several registers become eligible in the same cycle, they are released one per cycle, lowest index first.
- R6: A mispredict (`mp_valid`) selects every released register whose overwrite was speculative and whose checkpoint id (`ren_ckpt`, bit n of `mp_mask` for id n) is in the mask. Each selected register gets one copy-back request per cycle, lowest index first, starting the cycle after the mispredict. Each request carries the location recorded when that register was allocated.
- R7: A commit of the overwriting instruction (`cmt_valid` with the old register) clears its speculative state, so the register is never copied back.
- R8: `rec_done` is a one-cycle pulse in cycle max(5, k+1) after the mispredict edge, where k is the number of copy-back requests.
- R9: While recovery is in progress, rename and mispredict inputs are ignored.
- R10: A copied-back register is live again and is not released until it is remapped once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | A mapping change is renamed this cycle |
| ren_new_preg | input | 4 | Newly allocated physical register |
| ren_old_preg | input | 4 | Previous mapping of the same logical register |
| ren_spec | input | 1 | An older branch is still unresolved |
| ren_ckpt | input | 2 | Checkpoint id of the youngest unresolved branch |
| ren_loc | input | 8 | Duplicate-store location of the new register's value |
| rd_valid | input | 1 | A reader of a physical register is renamed |
| rd_preg | input | 4 | Register read by that reader |
| ren_stall | output | 1 | Reader count saturated; this rename is dropped |
| iss_valid | input | 1 | A reader obtained its operand |
| iss_preg | input | 4 | Register that was read |
| cmt_valid | input | 1 | An overwriting instruction committed |
| cmt_preg | input | 4 | Old register of that instruction |
| mp_valid | input | 1 | Branch mispredict |
| mp_mask | input | 4 | Squashed checkpoint ids |
| rel_valid | output | 1 | Release pulse to the free list |
| rel_preg | output | 4 | Released register |
| cb_valid | output | 1 | Copy-back request |
| cb_preg | output | 4 | Register to restore |
| cb_loc | output | 8 | Location of its duplicate value |
| rec_done | output | 1 | Recovery finished |

## Verification
The hardest state to reach from the ports is a register that is released, still speculative, and tagged with a particular checkpoint. Reaching it takes an allocation that records a location, a later remap under an unresolved branch, and a drained reader count. The stimulus table builds several such registers with different checkpoint ids, releases them in order, and retires one of them through commit. A single mispredict mask then covers both a still-speculative register and the committed one. Two eligible registers in one cycle come from a rename of a reader-free register in the same cycle as the last issue of another register.

// File: rtl/erl_pkg.sv
package erl_pkg;
  // Per-register state flags.
  typedef struct packed {
    logic ow;    // logical register has a newer mapping
    logic fre;   // handed back to the free list
    logic spec;  // overwriting instruction not yet committed
  } preg_flags_t;
endpackage

// File: rtl/erl_lowest.sv
module erl_lowest #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/erl_recover.sv
module erl_recover #(
  parameter int N   = 16,
  parameter int IW  = 4,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N-1:0]  start_vec,
  output logic          busy,
  output logic          cb_valid,
  output logic [IW-1:0] cb_idx,
  output logic          done
);
  localparam int LAT_W = $clog2(LAT + 1);

  logic [N-1:0]     pend_q, pend_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             busy_q, busy_d;
  logic             found;
  logic [IW-1:0]    idx;

  erl_lowest #(.N(N), .IW(IW)) u_pick (.req(pend_q), .found(found), .idx(idx));

  assign busy     = busy_q;
  assign cb_valid = busy_q & found;
  assign cb_idx   = idx;
  assign done     = busy_q & ~found & (lat_q == '0);

  always_comb begin
    pend_d = pend_q;
    lat_d  = lat_q;
    busy_d = busy_q;
    if (start) begin
      pend_d = start_vec;
      lat_d  = LAT_W'(LAT - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (found) pend_d[idx] = 1'b0;
      if (lat_q != '0) lat_d = lat_q - 1'b1;
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      lat_q  <= '0;
      busy_q <= 1'b0;
    end else if (start || busy_q) begin
      pend_q <= pend_d;
      lat_q  <= lat_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/eager_release_tracker.sv
module eager_release_tracker #(
  parameter int NPREG = 16,
  parameter int PW    = 4,
  parameter int CNT_W = 2,
  parameter int NCKPT = 4,
  parameter int CW    = 2,
  parameter int LOC_W = 8,
  parameter int LAT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  input  logic [PW-1:0]    ren_new_preg,
  input  logic [PW-1:0]    ren_old_preg,
  input  logic             ren_spec,
  input  logic [CW-1:0]    ren_ckpt,
  input  logic [LOC_W-1:0] ren_loc,
  input  logic             rd_valid,
  input  logic [PW-1:0]    rd_preg,
  output logic             ren_stall,
  input  logic             iss_valid,
  input  logic [PW-1:0]    iss_preg,
  input  logic             cmt_valid,
  input  logic [PW-1:0]    cmt_preg,
  input  logic             mp_valid,
  input  logic [NCKPT-1:0] mp_mask,
  output logic             rel_valid,
  output logic [PW-1:0]    rel_preg,
  output logic             cb_valid,
  output logic [PW-1:0]    cb_preg,
  output logic [LOC_W-1:0] cb_loc,
  output logic             rec_done
);
  import erl_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_all [NPREG];
  logic [LOC_W-1:0] loc_all [NPREG];
  logic [NPREG-1:0] elig, cand;
  logic             rec_busy, ren_go, rd_go, mp_go;

  assign ren_stall = rd_valid & (cnt_all[rd_preg] == CNT_MAX);
  assign ren_go    = ren_valid & ~rec_busy & ~ren_stall;
  assign rd_go     = rd_valid & ~rec_busy & ~ren_stall;
  assign mp_go     = mp_valid & ~rec_busy;

  for (genvar g = 0; g < NPREG; g++) begin : g_preg
    preg_flags_t      flg_q, flg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CW-1:0]    tag_q;
    logic [LOC_W-1:0] loc_q;
    logic             inc, dec, hit_new, hit_old, hit_rel, hit_cb;

    assign inc     = rd_go && (rd_preg == PW'(g));
    assign dec     = iss_valid && (iss_preg == PW'(g)) && (cnt_q != '0);
    assign hit_new = ren_go && (ren_new_preg == PW'(g));
    assign hit_old = ren_go && (ren_old_preg == PW'(g));
    assign hit_rel = rel_valid && (rel_preg == PW'(g));
    assign hit_cb  = cb_valid && (cb_preg == PW'(g));

    always_comb begin
      flg_d = flg_q;
      cnt_d = cnt_q;
      if (inc && !dec) cnt_d = cnt_q + 1'b1;
      else if (dec && !inc) cnt_d = cnt_q - 1'b1;
      if (hit_rel) flg_d.fre = 1'b1;
      if (cmt_valid && (cmt_preg == PW'(g))) flg_d.spec = 1'b0;
      if (hit_old) begin
        flg_d.ow   = 1'b1;
        flg_d.spec = ren_spec;
      end
      if (hit_cb) flg_d = '0;
      if (hit_new) begin
        flg_d = '0;
        cnt_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q <= '0;
        cnt_q <= '0;
      end else begin
        flg_q <= flg_d;
        cnt_q <= cnt_d;
      end
    end

    // Datapath fields: written on enable only, no reset.
    always_ff @(posedge clk) begin
      if (hit_old) tag_q <= ren_ckpt;
      if (hit_new) loc_q <= ren_loc;
    end

    assign cnt_all[g] = cnt_q;
    assign loc_all[g] = loc_q;
    assign elig[g]    = flg_q.ow & ~flg_q.fre & (cnt_q == '0);
    assign cand[g]    = flg_q.fre & flg_q.spec & mp_mask[tag_q];
  end

  erl_lowest #(.N(NPREG), .IW(PW)) u_rel_pick (
    .req(elig), .found(rel_valid), .idx(rel_preg)
  );

  erl_recover #(.N(NPREG), .IW(PW), .LAT(LAT)) u_recover (
    .clk(clk), .rst_n(rst_n), .start(mp_go), .start_vec(cand),
    .busy(rec_busy), .cb_valid(cb_valid), .cb_idx(cb_preg), .done(rec_done)
  );

  assign cb_loc = loc_all[cb_preg];
endmodule

// File: rtl/eager_release_tracker_chk.sv
module eager_release_tracker_chk #(
  parameter int PW  = 4,
  parameter int LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mp_valid,
  input logic          rel_valid,
  input logic [PW-1:0] rel_preg,
  input logic          cb_valid,
  input logic          rec_done,
  input logic          ren_stall,
  input logic          rd_valid,
  input logic          busy
);
  // R2: a register is not reported twice in back-to-back cycles
  p_single_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !(rel_valid && rel_preg == $past(rel_preg)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  // R8: done never coincides with an outstanding copy-back request
  p_done_after_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> !rec_done);

  // R6: copy-back requests only while recovery runs
  p_cb_in_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> busy);

  // R8: a freshly started recovery is not done in its first cycle
  p_min_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 1) && mp_valid && !busy |=> !rec_done);

  // R4: stall only with a reader request
  p_stall_needs_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |-> rd_valid);
endmodule

bind eager_release_tracker eager_release_tracker_chk #(.PW(PW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mp_valid(mp_valid), .rel_valid(rel_valid),
  .rel_preg(rel_preg), .cb_valid(cb_valid), .rec_done(rec_done),
  .ren_stall(ren_stall), .rd_valid(rd_valid), .busy(rec_busy)
);

// File: tb/eager_release_tracker_bench.sv
module eager_release_tracker_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, ren_spec, rd_valid, iss_valid, cmt_valid, mp_valid;
  logic [3:0] ren_new_preg, ren_old_preg, rd_preg, iss_preg, cmt_preg;
  logic [1:0] ren_ckpt;
  logic [7:0] ren_loc;
  logic [3:0] mp_mask;
  logic ren_stall, rel_valid, cb_valid, rec_done;
  logic [3:0] rel_preg, cb_preg;
  logic [7:0] cb_loc;

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;

  eager_release_tracker u_eager_release_tracker (.*);

  typedef struct packed {
    logic       rv; logic [3:0] nw; logic [3:0] od; logic sp; logic [1:0] ck; logic [7:0] lc;
    logic       dv; logic [3:0] dp;
    logic       iv; logic [3:0] ip;
    logic       er; logic [3:0] ep;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b1, 4'd2,  1'b0, 4'd0,  1'b0, 4'd0 },  // R3 reader on 2
    '{1'b1, 4'd1,  4'd2,  1'b0, 2'd0, 8'h11, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 },  // R3 2 overwritten, count 1
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 },  // R3 still held
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b1, 4'd2,  1'b1, 4'd2 },  // R2 drained -> release 2
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 },  // R2 only once
    '{1'b1, 4'd5,  4'd9,  1'b0, 2'd0, 8'h55, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd9 },  // R2
    '{1'b1, 4'd7,  4'd4,  1'b0, 2'd0, 8'h77, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd4 },  // R2
    '{1'b1, 4'd8,  4'd5,  1'b1, 2'd1, 8'h88, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd5 },  // R2 speculative
    '{1'b1, 4'd10, 4'd7,  1'b1, 2'd2, 8'hA0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd7 },  // R2 speculative
    '{1'b1, 4'd12, 4'd1,  1'b1, 2'd3, 8'hC0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd1 },  // R2 speculative
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b1, 4'd14, 1'b0, 4'd0,  1'b0, 4'd0 },  // R3
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b1, 4'd13, 1'b0, 4'd0,  1'b0, 4'd0 },  // R3
    '{1'b1, 4'd11, 4'd14, 1'b0, 2'd0, 8'hB0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 },  // R3
    '{1'b1, 4'd15, 4'd13, 1'b0, 2'd0, 8'hF0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 },  // R3
    '{1'b1, 4'd0,  4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b1, 4'd14, 1'b1, 4'd6 },  // R5 6 and 14 together
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd14},  // R5 then 14
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b1, 4'd13, 1'b1, 4'd13},  // R3
    '{1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 8'h00, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0 }   // R5 drained
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ren_valid = 0; ren_new_preg = 0; ren_old_preg = 0; ren_spec = 0; ren_ckpt = 0;
    ren_loc = 0; rd_valid = 0; rd_preg = 0; iss_valid = 0; iss_preg = 0;
    cmt_valid = 0; cmt_preg = 0; mp_valid = 0; mp_mask = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk("R1 rel_valid", rel_valid, 0);
    chk("R1 cb_valid", cb_valid, 0);
    chk("R1 rec_done", rec_done, 0);
    chk("R1 ren_stall", ren_stall, 0);
    step();
    chk("R1 nothing overwritten", rel_valid, 0);

    for (int i = 0; i < NV; i++) begin
      ren_valid = VEC[i].rv; ren_new_preg = VEC[i].nw; ren_old_preg = VEC[i].od;
      ren_spec = VEC[i].sp; ren_ckpt = VEC[i].ck; ren_loc = VEC[i].lc;
      rd_valid = VEC[i].dv; rd_preg = VEC[i].dp;
      iss_valid = VEC[i].iv; iss_preg = VEC[i].ip;
      step();
      chk($sformatf("R2/R3/R5 vec%0d rel_valid", i), rel_valid, VEC[i].er);
      if (VEC[i].er) chk($sformatf("R5 vec%0d rel_preg", i), rel_preg, VEC[i].ep);
    end

    // R7: retire the overwriter of register 7
    cmt_valid = 1; cmt_preg = 4'd7;
    step();
    chk("R7 no release", rel_valid, 0);

    // R6: squash checkpoints 1..3; candidates 1 (ckpt3) and 5 (ckpt1), 7 committed
    mp_valid = 1; mp_mask = 4'b1110;
    step();
    chk("R6 first cb_valid", cb_valid, 1);
    chk("R6 first cb_preg", cb_preg, 1);
    chk("R6 first cb_loc", cb_loc, 8'h11);
    chk("R8 not done c1", rec_done, 0);
    // R9: rename during recovery must be ignored
    ren_valid = 1; ren_new_preg = 4'd2; ren_old_preg = 4'd11;
    step();
    chk("R6 second cb_valid", cb_valid, 1);
    chk("R6 second cb_preg", cb_preg, 5);
    chk("R6 second cb_loc", cb_loc, 8'h55);
    chk("R8 not done c2", rec_done, 0);
    step();
    chk("R7 no copy-back of committed", cb_valid, 0);
    chk("R9 ignored rename no release c3", rel_valid, 0);
    step();
    chk("R8 not done c4", rec_done, 0);
    step();
    chk("R8 done c5", rec_done, 1);
    chk("R10 no release c5", rel_valid, 0);
    step();
    chk("R8 done pulse ends", rec_done, 0);
    chk("R9 no release", rel_valid, 0);
    step();
    chk("R10 restored not released", rel_valid, 0);

    // R8 with no candidates: done still waits the full latency
    mp_valid = 1; mp_mask = 4'b0001;
    step();
    chk("R8 empty no cb", cb_valid, 0);
    for (int c = 2; c <= 4; c++) begin
      step();
      chk($sformatf("R8 empty not done c%0d", c), rec_done, 0);
    end
    step();
    chk("R8 empty done c5", rec_done, 1);
    step();

    // R4: saturate the reader count of 15
    for (int k = 0; k < 3; k++) begin
      rd_valid = 1; rd_preg = 4'd15;
      #1;
      chk("R4 no stall below max", ren_stall, 0);
      step();
    end
    rd_valid = 1; rd_preg = 4'd15;
    ren_valid = 1; ren_new_preg = 4'd3; ren_old_preg = 4'd12;
    #1;
    chk("R4 stall at max", ren_stall, 1);
    step();
    chk("R4 dropped rename no release", rel_valid, 0);
    step();
    chk("R4 dropped rename still none", rel_valid, 0);
    iss_valid = 1; iss_preg = 4'd15;
    step();
    rd_valid = 1; rd_preg = 4'd15;
    #1;
    chk("R4 stall clears after issue", ren_stall, 0);
    step();

    finish_run();
  end
endmodule